// File: doc/BRIEF.md
# PHY Test-Interface Configuration Port

This block is the PHY-side end of a byte-wide test and configuration interface. An outside agent sends an 8-bit register address and then an 8-bit data value over the same byte bus. A slow strobe line and a select line tell the two phases apart. All four test inputs come from another clock domain. The block passes them through two-flop synchronisers and finds the strobe edges in the system clock domain. Each strobe level must therefore last at least three system clocks.

A falling strobe edge with the select line high latches the bus value as the current register address. A later rising strobe edge with the select line low writes the bus value into that register. The register that the current address selects is always visible on a read-back byte. The block also drives its settings straight to the receiver lanes:

- the clock-lane receive control byte,
- the six-bit frequency-band field of each data lane,
- the settle-time threshold byte,
- a flag that shows a write to address 0x00, which returns the PHY to normal operation.

A clear input returns everything to its defaults.

Top module: `phy_cfg_port`

## Requirements
- R1: A falling strobe edge seen while the select line is high captures the byte bus as the current address.
- R2: A rising strobe edge seen while the select line is low writes the byte bus into the register at the current address. Read-back then shows the new value.
- R3: A rising strobe edge seen while the select line is still high writes nothing.
- R4: A falling strobe edge seen while the select line is low leaves the current address unchanged.
- R5: The implemented registers sit at these addresses: clock-lane control at 0x34, data lanes 0 to 3 at 0x44, 0x54, 0x84 and 0x94, and settle threshold at 0x75. Each one reads back exactly what was written.
- R6: The band output of each data lane is bits [6:1] of that lane's control byte. Lane n occupies `lane_band[6n+5:6n]`, and bits 0 and 7 are excluded. The clock-lane control byte and the settle byte are output whole.
- R7: A write to address 0x00 sets `normal_op`, which stays set until a clear. Address 0x00 reads back as 0x00.
- R8: Asynchronous reset, or a clear request, sets all registers, the current address and `normal_op` to zero.
- R9: Every other address reads 0x00. A write to such an address changes no output.
- R10: A strobe edge applied just before a system clock edge shows at the outputs after the third system clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tst_strobe | input | 1 | Test strobe (asynchronous) |
| tst_sel | input | 1 | High = address phase, low = data phase (asynchronous) |
| tst_bus | input | 8 | Shared address/data byte (asynchronous) |
| tst_clear | input | 1 | Clear request, active high (asynchronous) |
| tst_rdata | output | 8 | Register at the current address |
| clk_lane_ctrl | output | 8 | Clock-lane receive control byte |
| lane_band | output | 24 | Per-data-lane frequency-band fields |
| settle_thr | output | 8 | Settle-time threshold byte |
| normal_op | output | 1 | Set by a write to address 0x00 |

## Verification
Every implemented register is read back through `tst_rdata`. A wrong stored value, or an address latched in the wrong phase, shows there three system clocks after the offending strobe edge. A write that lands in the wrong slot shows in the decoded lane outputs at the same moment. The bench checks the exact three-clock edge as well. A lost or extra synchroniser stage therefore shows as a read-back that changes one cycle early or one cycle late.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_DLANES = 4;
  localparam int BAND_W     = 6;
  localparam int BAND_LSB   = 1;
  localparam int NUM_SLOTS  = NUM_DLANES + 2;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int SLOT_CLK    = 0;
  localparam int SLOT_SETTLE = 1;
  localparam int SLOT_DLANE0 = 2;

  localparam logic [BYTE_W-1:0] CODE_NORMAL   = 8'h00;
  localparam logic [BYTE_W-1:0] CODE_CLK_LANE = 8'h34;
  localparam logic [BYTE_W-1:0] CODE_SETTLE   = 8'h75;
  localparam logic [NUM_DLANES-1:0][BYTE_W-1:0] CODE_DLANE =
    {8'h94, 8'h84, 8'h54, 8'h44};

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] idx;
  } slot_t;

  function automatic slot_t decode_code(input logic [BYTE_W-1:0] code);
    slot_t s;
    s = '0;
    if (code == CODE_CLK_LANE) begin
      s.hit = 1'b1;
      s.idx = SLOT_W'(SLOT_CLK);
    end
    if (code == CODE_SETTLE) begin
      s.hit = 1'b1;
      s.idx = SLOT_W'(SLOT_SETTLE);
    end
    for (int i = 0; i < NUM_DLANES; i++) begin
      if (code == CODE_DLANE[i]) begin
        s.hit = 1'b1;
        s.idx = SLOT_W'(SLOT_DLANE0 + i);
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/phy_cfg_sync.sv
module phy_cfg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/phy_cfg_edge.sv
module phy_cfg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/phy_cfg_regfile.sv
module phy_cfg_regfile
  import phy_cfg_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              rise,
  input  logic                              fall,
  input  logic                              sel,
  input  logic [BYTE_W-1:0]                 din,
  output logic [BYTE_W-1:0]                 dout,
  output logic [BYTE_W-1:0]                 code,
  output logic [NUM_SLOTS-1:0][BYTE_W-1:0]  regs,
  output logic                              normal_op
);
  logic  wr_stb;
  logic  cap_stb;
  slot_t cur;

  assign wr_stb  = rise & ~sel;
  assign cap_stb = fall & sel;
  assign cur     = decode_code(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code      <= '0;
      regs      <= '0;
      normal_op <= 1'b0;
    end else if (clr) begin
      code      <= '0;
      regs      <= '0;
      normal_op <= 1'b0;
    end else begin
      if (cap_stb) code <= din;
      if (wr_stb) begin
        if (cur.hit) regs[cur.idx] <= din;
        if (code == CODE_NORMAL) normal_op <= 1'b1;
      end
    end
  end

  always_comb begin
    dout = '0;
    if (cur.hit) dout = regs[cur.idx];
  end

  p_code_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && !clr) |=> (code == $past(din)));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !clr && cur.hit) |=> (dout == $past(din)));

  p_no_write_sel_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && sel && !clr) |=> $stable(regs));

  p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_stb && !clr) |=> $stable(code));

  p_normal_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !clr && code == CODE_NORMAL) |=> normal_op);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (code == '0 && regs == '0 && !normal_op));
endmodule

// File: rtl/phy_cfg_port.sv
module phy_cfg_port
  import phy_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tst_strobe,
  input  logic                          tst_sel,
  input  logic [BYTE_W-1:0]             tst_bus,
  input  logic                          tst_clear,
  output logic [BYTE_W-1:0]             tst_rdata,
  output logic [BYTE_W-1:0]             clk_lane_ctrl,
  output logic [NUM_DLANES*BAND_W-1:0]  lane_band,
  output logic [BYTE_W-1:0]             settle_thr,
  output logic                          normal_op
);
  localparam int SYNC_W = BYTE_W + 3;

  logic [SYNC_W-1:0]                 raw_in;
  logic [SYNC_W-1:0]                 syn;
  logic                              s_strobe;
  logic                              s_sel;
  logic                              s_clear;
  logic [BYTE_W-1:0]                 s_bus;
  logic                              rise;
  logic                              fall;
  logic [BYTE_W-1:0]                 cur_code;
  logic [NUM_SLOTS-1:0][BYTE_W-1:0]  regs;

  assign raw_in = {tst_clear, tst_strobe, tst_sel, tst_bus};
  assign {s_clear, s_strobe, s_sel, s_bus} = syn;

  phy_cfg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  phy_cfg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(s_strobe), .rise(rise), .fall(fall)
  );

  phy_cfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .clr(s_clear), .rise(rise), .fall(fall),
    .sel(s_sel), .din(s_bus), .dout(tst_rdata), .code(cur_code),
    .regs(regs), .normal_op(normal_op)
  );

  assign clk_lane_ctrl = regs[SLOT_CLK];
  assign settle_thr    = regs[SLOT_SETTLE];

  for (genvar g = 0; g < NUM_DLANES; g++) begin : g_lane
    assign lane_band[g*BAND_W +: BAND_W] = regs[SLOT_DLANE0 + g][BAND_LSB +: BAND_W];
  end

  p_unimpl_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_rdata != '0) |-> decode_code(cur_code).hit);
endmodule

// File: tb/phy_cfg_port_bench.sv
module phy_cfg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tst_strobe = 1'b0;
  logic        tst_sel = 1'b1;
  logic [7:0]  tst_bus = 8'h00;
  logic        tst_clear = 1'b0;
  logic [7:0]  tst_rdata;
  logic [7:0]  clk_lane_ctrl;
  logic [23:0] lane_band;
  logic [7:0]  settle_thr;
  logic        normal_op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phy_cfg_port u_phy_cfg_port (
    .clk(clk), .rst_n(rst_n), .tst_strobe(tst_strobe), .tst_sel(tst_sel),
    .tst_bus(tst_bus), .tst_clear(tst_clear), .tst_rdata(tst_rdata),
    .clk_lane_ctrl(clk_lane_ctrl), .lane_band(lane_band),
    .settle_thr(settle_thr), .normal_op(normal_op)
  );

  // {address, data, expected read-back}
  localparam logic [23:0] VEC [8] = '{
    {8'h34, 8'hA5, 8'hA5},
    {8'h44, 8'h7E, 8'h7E},
    {8'h54, 8'h81, 8'h81},
    {8'h84, 8'h3C, 8'h3C},
    {8'h94, 8'hFF, 8'hFF},
    {8'h75, 8'h04, 8'h04},
    {8'h10, 8'h55, 8'h00},
    {8'hFF, 8'h12, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (5) @(negedge clk);
  endtask

  task automatic sel_code(input logic [7:0] c);
    tst_sel = 1'b1; tst_bus = c; tst_strobe = 1'b1; hold();
    tst_strobe = 1'b0; hold();
  endtask

  task automatic write_reg(input logic [7:0] c, input logic [7:0] d);
    sel_code(c);
    tst_sel = 1'b0; tst_bus = d; hold();
    tst_strobe = 1'b1; hold();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold();
    // R8 reset state
    chk("R8 reset rdata", tst_rdata, 0);
    chk("R8 reset outputs", {clk_lane_ctrl, settle_thr, lane_band}, 0);
    chk("R7 reset normal_op", normal_op, 0);

    // R2 R5 R9 table walk
    for (int i = 0; i < 8; i++) begin
      write_reg(VEC[i][23:16], VEC[i][15:8]);
      chk(VEC[i][7:0] == 0 ? "R9 unimplemented readback" : "R2 R5 readback",
          tst_rdata, VEC[i][7:0]);
    end

    // R6 lane outputs; R9 unimplemented writes changed nothing
    chk("R6 clock lane byte", clk_lane_ctrl, 8'hA5);
    chk("R6 settle byte", settle_thr, 8'h04);
    chk("R6 lane bands", lane_band, {6'h3F, 6'h1E, 6'h00, 6'h3F});
    chk("R7 normal_op still clear", normal_op, 0);

    // R1 capture
    sel_code(8'h34);
    chk("R1 capture address", tst_rdata, 8'hA5);

    // R3 rising edge with select high
    tst_sel = 1'b1; tst_bus = 8'h99; tst_strobe = 1'b1; hold();
    chk("R3 no write while select high", tst_rdata, 8'hA5);
    chk("R3 clock lane unchanged", clk_lane_ctrl, 8'hA5);

    // R4 falling edge with select low
    tst_sel = 1'b0; tst_bus = 8'h44; hold();
    tst_strobe = 1'b0; hold();
    chk("R4 address kept", tst_rdata, 8'hA5);
    tst_sel = 1'b1; tst_strobe = 1'b1; hold();

    // R10 latency
    sel_code(8'h44);
    chk("R10 start address", tst_rdata, 8'h7E);
    tst_sel = 1'b1; tst_bus = 8'h54; tst_strobe = 1'b1; hold();
    tst_strobe = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 not after two edges", tst_rdata, 8'h7E);
    @(posedge clk); @(negedge clk);
    chk("R10 visible after three edges", tst_rdata, 8'h81);
    hold();

    // R7 normal operation
    write_reg(8'h00, 8'h5A);
    chk("R7 normal_op set", normal_op, 1);
    chk("R7 address 0 reads zero", tst_rdata, 0);
    chk("R7 clock lane unchanged", clk_lane_ctrl, 8'hA5);
    sel_code(8'h34); hold();
    chk("R7 normal_op sticky", normal_op, 1);

    // R8 clear
    tst_clear = 1'b1; hold();
    tst_clear = 1'b0; hold();
    chk("R8 clear rdata", tst_rdata, 0);
    chk("R8 clear outputs", {clk_lane_ctrl, settle_thr, lane_band}, 0);
    chk("R8 clear normal_op", normal_op, 0);
    sel_code(8'h75);
    chk("R8 settle cleared", tst_rdata, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule